// File: doc/BRIEF.md
# Serial Program Counter with Status Flags

This block keeps the instruction address of a bit-serial processor, a single saved return address and twelve status flags. All three share one 28-bit recirculating shift register that advances one place per clock, so every slot passes the register head twice per 56-bit word. An externally supplied word-position count (`bit_cnt`, 0 to 55, advancing by one per clock) fixes which slot is at the head in each cycle. Address at positions 19..26 (and 47..54), return slot at 11..18 (and 39..46), flag k at position 27+k (modulo 28).

The instruction of a word arrives one bit per clock on `instr_bit` during positions 45..54. Its first two bits choose the kind: jump to subroutine, conditional branch, miscellaneous, or no operation. The remaining eight bits are a target address or a miscellaneous operation. The decoded instruction acts during the following word. In that word the block shifts the next fetch address out on `addr_out` while `addr_valid` is high. It may replace that address with a branch target or with the return slot. It also updates or tests one flag. A successful test raises `cond_hit`, which the surrounding logic uses to set its carry flip-flop. The address line is a fixed-timing stream: it has no ready input and cannot be stalled, so a consumer must take each bit in the cycle it appears.

Top module: `serial_pc`

## Requirements
- R1: After reset the address, return slot and all flags are zero, `addr_out`, `addr_valid` and `cond_hit` are low, and the first word emits address 0.
- R2: `addr_valid` is high exactly at positions 19..26. The address appears there least significant bit first, and `addr_out` is low whenever `addr_valid` is low.
- R3: At positions 47..54 of every word the stored address is incremented by one through a serial adder, wrapping from 255 to 0. With no other instruction, each word emits the previous word's address plus one.
- R4: Instruction bits 1,0 (first bit at position 45 equal to 1, bit at 46 equal to 0) mark a jump to subroutine. The eight bits at 47..54 (LSB first) become the address emitted in the next word, and the incremented address is saved in the return slot.
- R5: Only one return level exists: a second jump to subroutine overwrites the saved return address.
- R6: A miscellaneous instruction (bits 0,1 at positions 45,46) with operation code 00 in target bits [1:0] makes the next word emit the return slot contents. That value also becomes the stored address.
- R7: Instruction bits 1,1 mark a conditional branch to the eight target bits. `carry_in` is sampled at position 19 of the next word. If it is 0 the target is emitted and stored; if it is 1 the incremented address is emitted.
- R8: Miscellaneous operation codes 01 and 10 set or clear the flag whose index is in target bits [5:2]. The change takes effect during the next word.
- R9: Miscellaneous operation code 11 tests the indexed flag during the next word. If the flag is set, `cond_hit` is high for exactly one cycle within positions 28..39; otherwise it stays low for the word.
- R10: A pulse on `key_evt` sets flag 0 no later than the next pass of that flag. A set from `key_evt` wins over a clear in the same pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_cnt | input | 6 | Word position 0..55, advancing by one each cycle |
| instr_bit | input | 1 | Serial instruction stream, valid at positions 45..54 |
| carry_in | input | 1 | Carry flip-flop state, sampled at position 19 for a pending branch |
| key_evt | input | 1 | Key-pressed event, sets flag 0 |
| addr_out | output | 1 | Serial fetch address, LSB first |
| addr_valid | output | 1 | High while `addr_out` carries an address bit |
| cond_hit | output | 1 | One-cycle pulse when a flag test finds the flag set |

## Verification
The hardest situation to reach is a return that must use a return slot overwritten by a second jump to subroutine. Two jumps have to come in back-to-back words, and the return only becomes visible two words later, on the address line. The stimulus builds every instruction bit by bit at the right word positions. A reference model tracks address, return slot and flags word by word, so sequences of jumps, branches with either carry and returns can be chained freely. Flag state is brought out only through test instructions, so each set, clear or key event is followed by a test whose pulse count in the next word is compared.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int WORD_LEN = 56;
  localparam int CNT_W    = $clog2(WORD_LEN);
  localparam int ADDR_W   = 8;
  localparam int FLAG_N   = 12;
  localparam int FIDX_W   = $clog2(FLAG_N);
  localparam int RING_LEN = WORD_LEN / 2;
  localparam int OPC_W    = 2;

  // Word positions (bit times) that fix the timing of every slot
  localparam logic [CNT_W-1:0] T_RET0  = CNT_W'(11);
  localparam logic [CNT_W-1:0] T_RET1  = CNT_W'(18);
  localparam logic [CNT_W-1:0] T_OUT0  = CNT_W'(19);
  localparam logic [CNT_W-1:0] T_OUT1  = CNT_W'(26);
  localparam logic [CNT_W-1:0] T_FLAG0 = CNT_W'(27);
  localparam logic [CNT_W-1:0] T_FLAG1 = CNT_W'(27 + FLAG_N - 1);
  localparam logic [CNT_W-1:0] T_TYPE0 = CNT_W'(45);
  localparam logic [CNT_W-1:0] T_TYPE1 = CNT_W'(46);
  localparam logic [CNT_W-1:0] T_INC0  = CNT_W'(47);
  localparam logic [CNT_W-1:0] T_INC1  = CNT_W'(47 + ADDR_W - 1);
  localparam logic [CNT_W-1:0] T_LAST  = CNT_W'(WORD_LEN - 1);

  typedef enum logic [2:0] {
    OP_NONE, OP_JSB, OP_BR, OP_RET, OP_SET, OP_CLR, OP_TST
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [FIDX_W-1:0] idx;
    logic [ADDR_W-1:0] tgt;
  } pend_t;
endpackage

// File: rtl/spc_decode.sv
module spc_decode
  import spc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             instr_bit,
  output logic             cur_jsb,
  output logic             cur_br,
  output pend_t            pend
);
  logic              kind0, kind1;
  logic [ADDR_W-1:0] fld;
  pend_t             pend_nx;
  logic              in_fld;

  assign in_fld  = (bit_cnt >= T_INC0) && (bit_cnt <= T_INC1);
  assign cur_jsb = kind0 & ~kind1;
  assign cur_br  = kind0 & kind1;

  always_comb begin
    pend_nx.tgt = fld;
    pend_nx.idx = fld[OPC_W +: FIDX_W];
    unique case ({kind1, kind0})
      2'b01:   pend_nx.op = OP_JSB;
      2'b11:   pend_nx.op = OP_BR;
      2'b10: begin
        unique case (fld[OPC_W-1:0])
          2'b00:   pend_nx.op = OP_RET;
          2'b01:   pend_nx.op = OP_SET;
          2'b10:   pend_nx.op = OP_CLR;
          default: pend_nx.op = OP_TST;
        endcase
      end
      default: pend_nx.op = OP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind0 <= 1'b0;
      kind1 <= 1'b0;
      fld   <= '0;
      pend  <= '{op: OP_NONE, idx: '0, tgt: '0};
    end else begin
      if (bit_cnt == T_TYPE0) kind0 <= instr_bit;
      if (bit_cnt == T_TYPE1) kind1 <= instr_bit;
      if (in_fld) fld <= {instr_bit, fld[ADDR_W-1:1]};
      if (bit_cnt == T_LAST) pend <= pend_nx;
    end
  end
endmodule

// File: rtl/spc_inc.sv
module spc_inc (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic en,
  input  logic a_bit,
  output logic sum_bit
);
  logic cy_q, cin;

  // The +1 enters as the carry into the least significant bit
  assign cin     = first ? 1'b1 : cy_q;
  assign sum_bit = a_bit ^ cin;

  always_ff @(posedge clk) begin
    if (!rst_n)  cy_q <= 1'b0;
    else if (en) cy_q <= a_bit & cin;
  end
endmodule

// File: rtl/serial_pc.sv
module serial_pc
  import spc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             instr_bit,
  input  logic             carry_in,
  input  logic             key_evt,
  output logic             addr_out,
  output logic             addr_valid,
  output logic             cond_hit
);
  logic [RING_LEN-1:0] ring;
  logic                head_nx;
  logic [ADDR_W-1:0]   sub_buf, save_buf;
  logic                take_q, take_now, sub_act;
  logic                key_pend, key_apply;
  logic                w_inc, w_out, w_ret, w_flag;
  logic [CNT_W-1:0]    fpos;
  logic                fmatch;
  logic                cur_jsb, cur_br, sum_bit;
  pend_t               pend;

  assign w_inc  = (bit_cnt >= T_INC0)  && (bit_cnt <= T_INC1);
  assign w_out  = (bit_cnt >= T_OUT0)  && (bit_cnt <= T_OUT1);
  assign w_ret  = (bit_cnt >= T_RET0)  && (bit_cnt <= T_RET1);
  assign w_flag = (bit_cnt >= T_FLAG0) && (bit_cnt <= T_FLAG1);
  assign fpos   = bit_cnt - T_FLAG0;
  assign fmatch = w_flag && (fpos == CNT_W'(pend.idx));

  spc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .bit_cnt(bit_cnt), .instr_bit(instr_bit),
    .cur_jsb(cur_jsb), .cur_br(cur_br), .pend(pend)
  );

  spc_inc u_inc (
    .clk(clk), .rst_n(rst_n), .first(bit_cnt == T_INC0), .en(w_inc),
    .a_bit(ring[0]), .sum_bit(sum_bit)
  );

  // Substitution decision: fixed at the first output bit, held for the rest
  assign take_now = (pend.op == OP_RET) || ((pend.op == OP_BR) && !carry_in);
  assign sub_act  = w_out && ((bit_cnt == T_OUT0) ? take_now : take_q);

  assign key_apply = key_pend && ((bit_cnt == T_FLAG0) || (bit_cnt == T_LAST));

  always_comb begin
    head_nx = ring[0];
    if (w_inc)
      head_nx = cur_jsb ? instr_bit : sum_bit;
    else if (w_out)
      head_nx = sub_act ? sub_buf[0] : ring[0];
    else if (w_ret && (pend.op == OP_JSB))
      head_nx = save_buf[0];
    else if (fmatch && (pend.op == OP_SET))
      head_nx = 1'b1;
    else if (fmatch && (pend.op == OP_CLR))
      head_nx = 1'b0;
    if (key_apply) head_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring     <= '0;
      sub_buf  <= '0;
      save_buf <= '0;
      take_q   <= 1'b0;
      key_pend <= 1'b0;
      cond_hit <= 1'b0;
    end else begin
      ring <= {head_nx, ring[RING_LEN-1:1]};

      if (w_inc && cur_br)
        sub_buf <= {instr_bit, sub_buf[ADDR_W-1:1]};
      else if (w_ret && (pend.op == OP_RET))
        sub_buf <= {ring[0], sub_buf[ADDR_W-1:1]};
      else if (sub_act)
        sub_buf <= {1'b0, sub_buf[ADDR_W-1:1]};

      if (w_inc && cur_jsb)
        save_buf <= {sum_bit, save_buf[ADDR_W-1:1]};
      else if (w_ret && (pend.op == OP_JSB))
        save_buf <= {1'b0, save_buf[ADDR_W-1:1]};

      if (bit_cnt == T_OUT0) take_q <= take_now;

      key_pend <= key_evt | (key_pend & ~key_apply);
      cond_hit <= fmatch && (pend.op == OP_TST) && ring[0];
    end
  end

  assign addr_valid = w_out;
  assign addr_out   = w_out && (sub_act ? sub_buf[0] : ring[0]);
endmodule

// File: rtl/serial_pc_chk.sv
module serial_pc_chk
  import spc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             addr_out,
  input logic             addr_valid,
  input logic             cond_hit
);
  // R2
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> !addr_out);

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && (bit_cnt != T_OUT1)) |=> addr_valid);

  // R9
  hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_hit |-> ((bit_cnt > T_FLAG0) && (bit_cnt <= T_FLAG1 + 1'b1)));

  // R9
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_hit |=> !cond_hit);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!cond_hit));
endmodule

bind serial_pc serial_pc_chk u_chk (.*);

// File: tb/tb_serial_pc.sv
`timescale 1ns/1ps
module tb_serial_pc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bit_cnt = '0;
  logic       instr_bit = 1'b0, carry_in = 1'b0, key_evt = 1'b0;
  logic       addr_out, addr_valid, cond_hit;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_pc dut (.*);

  localparam int K_NONE = 0, K_JSB = 1, K_BR = 2, K_RET = 3, K_SET = 4, K_CLR = 5, K_TST = 6;

  logic [7:0]  m_a = '0, m_r = '0, p_tgt = '0;
  logic [11:0] m_fl = '0;
  int          p_op = K_NONE, p_idx = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] jsb(input logic [7:0] t);  return {t, 2'b01}; endfunction
  function automatic logic [9:0] br(input logic [7:0] t);   return {t, 2'b11}; endfunction
  function automatic logic [9:0] misc(input logic [1:0] op, input int idx);
    return {2'b00, 4'(idx), op, 2'b10};
  endfunction
  localparam logic [9:0] NOP = 10'd0;

  // Driver: predicts the word's results, then drives its 56 bit times
  task automatic word(input logic [9:0] ins, input bit car, input bit key, input string tag);
    logic [7:0] o;
    int exp_hit = 0, hits = 0;
    if (p_op == K_RET) o = m_r;
    else if (p_op == K_BR && !car) o = p_tgt;
    else o = m_a;
    m_a = o;
    exp_q.push_back(o);
    tag_q.push_back(tag);
    if (p_op == K_TST && p_idx < 12) exp_hit = int'(m_fl[p_idx]);
    if (p_op == K_SET && p_idx < 12) m_fl[p_idx] = 1'b1;
    if (p_op == K_CLR && p_idx < 12) m_fl[p_idx] = 1'b0;
    if (key) m_fl[0] = 1'b1;
    if (ins[1:0] == 2'b01) begin
      m_r = m_a + 8'd1; m_a = ins[9:2]; p_op = K_JSB;
    end else begin
      m_a = m_a + 8'd1;
      p_tgt = ins[9:2];
      p_idx = int'(ins[7:4]);
      if (ins[1:0] == 2'b11) p_op = K_BR;
      else if (ins[1:0] == 2'b10) p_op = K_RET + int'(ins[3:2]);
      else p_op = K_NONE;
    end
    for (int b = 0; b < 56; b++) begin
      @(negedge clk);
      bit_cnt   = 6'(b);
      carry_in  = car;
      key_evt   = key && (b == 0);
      instr_bit = (b >= 45 && b <= 54) ? ins[b-45] : 1'b0;
      #1;
      if (cond_hit) hits++;
    end
    chk(hits == exp_hit, {tag, " R9 test pulses"}, hits, exp_hit);
  endtask

  // Monitor: gathers the serial address and compares with the scoreboard
  initial begin
    logic [7:0] acc;
    int n = 0;
    forever begin
      @(negedge clk); #1;
      if (rst_n && addr_valid) begin
        acc[n] = addr_out;
        n++;
        if (n == 8) begin
          n = 0;
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected address", int'(acc), -1);
          else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(acc == e, t, int'(acc), int'(e));
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!addr_valid && !addr_out && !cond_hit, "R1 outputs after reset", 
        int'({addr_valid, addr_out, cond_hit}), 0);

    word(NOP, 0, 0, "R1 first word address");
    word(NOP, 0, 0, "R3 increment");
    word(br(8'h5A), 0, 0, "R3 increment");
    word(br(8'h10), 0, 0, "R7 branch carry clear");
    word(NOP, 1, 0, "R7 branch carry set");
    word(NOP, 0, 0, "R3 after branch");
    word(jsb(8'hF0), 1, 0, "R3 before jump");
    word(NOP, 0, 0, "R4 jump target");
    word(misc(2'b00, 0), 0, 0, "R4 inside subroutine");
    word(NOP, 0, 0, "R6 return");
    word(jsb(8'h40), 0, 0, "R3 after return");
    word(jsb(8'h80), 0, 0, "R4 first jump");
    word(misc(2'b00, 0), 0, 0, "R5 second jump");
    word(NOP, 0, 0, "R5 overwritten return");
    word(br(8'hFF), 0, 0, "R3 plain");
    word(NOP, 0, 0, "R7 branch to top");
    word(misc(2'b01, 5), 0, 0, "R3 wrap to zero");
    word(misc(2'b11, 5), 0, 0, "R8 set flag 5");
    word(misc(2'b10, 5), 0, 0, "R9 flag 5 set");
    word(misc(2'b11, 5), 0, 0, "R8 clear flag 5");
    word(misc(2'b01, 11), 0, 0, "R9 flag 5 clear");
    word(misc(2'b11, 11), 0, 0, "R8 set flag 11");
    word(misc(2'b11, 4), 0, 0, "R9 flag 11 set");
    word(misc(2'b11, 0), 0, 0, "R9 flag 4 untouched");
    word(NOP, 0, 1, "R10 key before");
    word(misc(2'b11, 0), 0, 0, "R10 key event");
    word(misc(2'b10, 0), 0, 0, "R10 flag 0 set by key");
    word(misc(2'b11, 0), 0, 0, "R8 clear flag 0");
    word(NOP, 0, 0, "R9 flag 0 cleared");
    word(NOP, 0, 0, "R3 final");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all addresses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule